// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block decides when an analog-to-digital conversion begins and paces it, counting in system clock states. A conversion is launched by software setting the start bit, or, when the trigger source field selects the external pin, by a falling edge on that pin. The pin edge sets the same start bit, so the two launch paths behave the same from that point on. The block does not convert anything. It drives a sampling strobe for the analog front end, a busy flag, a per-channel completion pulse and the index of the channel being handled.

A 2-bit clock select sets the per-channel period T = 512 >> sel, giving 512, 256, 128 or 64 states. The sampling window is T/4 - 1 states and opens at the start of each channel's slot. Single mode adds a start delay of T/32 + 2 states before sampling, so one conversion keeps the block busy for 530, 266, 134 or 68 states. Single mode converts once and clears the start bit. Scan mode moves through the channels with no start delay and wraps back to channel 0 until software clears the start bit.

Top module: `adc_start_seq`

## Requirements
- R1: A write with the start field at 1 while idle makes the start bit read 1 after that clock edge. Busy rises one clock later.
- R2: Only when the trigger select field is binary 11 does a falling edge on the external pin set the start bit. Counting the first rising edge that samples the pin low as edge 1, the bit reads 1 after edge 3. Any other select value leaves the pin with no effect.
- R3: A single-mode conversion holds busy for D + T consecutive states, where T = 512 >> sel and D = T/32 + 2. Clock select 00, 01, 10 and 11 give 530, 266, 134 and 68 states.
- R4: In single mode the sampling strobe is high for T/4 - 1 consecutive states (127, 63, 31 or 15). It first rises in busy state D + 1.
- R5: When a single conversion finishes, conv_done pulses high for exactly one clock, in the first state after busy. In that same state both busy and the start bit read 0.
- R6: In scan mode each channel slot lasts T states, and the strobe rises together with busy because there is no start delay. conv_done pulses at the end of every slot. In that cycle chan_idx already shows the next channel, counting 0 up to NUM_CH-1 and wrapping, and busy and the start bit stay at 1.
- R7: A write with the start field at 0 while busy clears busy, the strobe, the start bit and chan_idx on the following clock, and no conv_done follows.
- R8: Writes to clock select, mode and trigger select made during a conversion are dropped. The running conversion keeps its timing and its mode.
- R9: A pin falling edge detected while busy, including in the final busy state, does not start another conversion.
- R10: A write with the start field at 0 that lands in the same cycle as a detected pin edge wins, and the start bit stays 0.
- R11: After reset the start bit, busy, strobe and conv_done are 0 and chan_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period is one state |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_trig_n | input | 1 | Asynchronous external trigger, acts on its falling edge |
| reg_we | input | 1 | Register write strobe |
| reg_start | input | 1 | Start field of the write |
| reg_scan | input | 1 | Mode field: 1 = scan, 0 = single |
| reg_trig_sel | input | 2 | Trigger source field; 11 selects the pin |
| reg_clk_sel | input | 2 | Clock select field |
| start_bit | output | 1 | Current start bit |
| sample_strobe | output | 1 | High during the input sampling window |
| busy | output | 1 | High while a conversion is in progress |
| conv_done | output | 1 | One-clock pulse at the end of each conversion |
| chan_idx | output | $clog2(NUM_CH) | Channel currently being handled |

## Verification
Two events can fall in the same cycle: the last busy state of a single conversion and a detected pin falling edge. The bench forces this by dropping the pin exactly two states before the final busy state. It then expects the start bit and busy to stay low, with no restart. A second collision puts a clearing software write in the same cycle as a detected pin edge, and the expected outcome is a start bit that stays 0.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DELAY  = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_CONV   = 2'd3
    } seq_phase_e;

    typedef struct packed {
        logic       scan;
        logic [1:0] trs;
        logic [1:0] cks;
    } seq_cfg_t;

    localparam logic [1:0] TRIG_FROM_PIN = 2'b11;

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic fall_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    // last stage holds the previous synchronized value
    assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

endmodule

// File: rtl/adc_phase_lut.sv
module adc_phase_lut #(
    parameter int BASE_STATES = 512,
    parameter int SMP_SHIFT   = 2,
    parameter int DLY_SHIFT   = 5,
    parameter int DLY_EXTRA   = 2,
    parameter int CW          = 10
) (
    input  logic [1:0]    cks_i,
    output logic [CW-1:0] dly_m1_o,
    output logic [CW-1:0] smp_m1_o,
    output logic [CW-1:0] cnv_m1_o
);
    localparam int N_SEL = 4;

    logic [CW-1:0] dly_tab [N_SEL];
    logic [CW-1:0] smp_tab [N_SEL];
    logic [CW-1:0] cnv_tab [N_SEL];

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        localparam int T_ST = BASE_STATES >> i;
        localparam int S_ST = (T_ST >> SMP_SHIFT) - 1;
        localparam int D_ST = (T_ST >> DLY_SHIFT) + DLY_EXTRA;
        assign dly_tab[i] = CW'(D_ST - 1);
        assign smp_tab[i] = CW'(S_ST - 1);
        assign cnv_tab[i] = CW'(T_ST - S_ST - 1);
    end

    assign dly_m1_o = dly_tab[cks_i];
    assign smp_m1_o = smp_tab[cks_i];
    assign cnv_m1_o = cnv_tab[cks_i];

endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int BASE_STATES = 512,
    parameter int SMP_SHIFT   = 2,
    parameter int DLY_SHIFT   = 5,
    parameter int DLY_EXTRA   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CHW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ext_trig_n,
    input  logic           reg_we,
    input  logic           reg_start,
    input  logic           reg_scan,
    input  logic [1:0]     reg_trig_sel,
    input  logic [1:0]     reg_clk_sel,
    output logic           start_bit,
    output logic           sample_strobe,
    output logic           busy,
    output logic           conv_done,
    output logic [CHW-1:0] chan_idx
);
    localparam int CW = $clog2(BASE_STATES + 1);
    localparam logic [CHW-1:0] LAST_CH = CHW'(NUM_CH - 1);

    typedef struct packed {
        seq_phase_e    phase;
        logic [CW-1:0] cnt;
        logic          start;
        logic          done;
        logic [CHW-1:0] ch;
        seq_cfg_t      cfg;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    seq_cfg_t      cfg_eff;
    logic          is_idle;
    logic          sw_clear;
    logic          trig_fall;
    logic [CW-1:0] dly_m1, smp_m1, cnv_m1;

    adc_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n_i(ext_trig_n),
        .fall_o (trig_fall)
    );

    adc_phase_lut #(
        .BASE_STATES(BASE_STATES),
        .SMP_SHIFT  (SMP_SHIFT),
        .DLY_SHIFT  (DLY_SHIFT),
        .DLY_EXTRA  (DLY_EXTRA),
        .CW         (CW)
    ) u_lut (
        .cks_i   (cfg_eff.cks),
        .dly_m1_o(dly_m1),
        .smp_m1_o(smp_m1),
        .cnv_m1_o(cnv_m1)
    );

    // configuration is taken only while idle
    always_comb begin
        is_idle  = (st_q.phase == PH_IDLE);
        sw_clear = reg_we & ~reg_start;
        if (is_idle && reg_we) begin
            cfg_eff.scan = reg_scan;
            cfg_eff.trs  = reg_trig_sel;
            cfg_eff.cks  = reg_clk_sel;
        end else begin
            cfg_eff = st_q.cfg;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.cfg  = cfg_eff;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (st_q.start) begin
                    st_d.ch = '0;
                    if (cfg_eff.scan) begin
                        st_d.phase = PH_SAMPLE;
                        st_d.cnt   = smp_m1;
                    end else begin
                        st_d.phase = PH_DELAY;
                        st_d.cnt   = dly_m1;
                    end
                end
            end
            PH_DELAY: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_SAMPLE;
                    st_d.cnt   = smp_m1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_SAMPLE: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_CONV;
                    st_d.cnt   = cnv_m1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_CONV: begin
                if (st_q.cnt == '0) begin
                    st_d.done = 1'b1;
                    if (st_q.cfg.scan) begin
                        st_d.phase = PH_SAMPLE;
                        st_d.cnt   = smp_m1;
                        st_d.ch    = (st_q.ch == LAST_CH) ? '0 : st_q.ch + 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.start = 1'b0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        // pin edge acts like a software set, only when idle
        if (is_idle && trig_fall && cfg_eff.trs == TRIG_FROM_PIN) begin
            st_d.start = 1'b1;
        end
        if (is_idle && reg_we && reg_start) begin
            st_d.start = 1'b1;
        end
        // software clear wins and aborts
        if (sw_clear) begin
            st_d.start = 1'b0;
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.ch    = '0;
            st_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.start <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.ch    <= '0;
            st_q.cfg   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic scan_cfg;
    assign scan_cfg      = st_q.cfg.scan;
    assign start_bit     = st_q.start;
    assign busy          = (st_q.phase != PH_IDLE);
    assign sample_strobe = (st_q.phase == PH_SAMPLE);
    assign conv_done     = st_q.done;
    assign chan_idx      = st_q.ch;

endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk #(
    parameter int NUM_CH = 4,
    parameter int CHW    = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_bit,
    input logic           sample_strobe,
    input logic           busy,
    input logic           conv_done,
    input logic           scan_cfg,
    input logic [CHW-1:0] chan_idx
);
    // R4
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> busy);
    // R5
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);
    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> $past(busy));
    // R5
    single_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !scan_cfg) |-> (!start_bit && !busy));
    // R1
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_bit));
    // R7
    busy_holds_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start_bit);
    // R6
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(chan_idx) < NUM_CH);
    // R7
    idle_chan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (chan_idx == '0));
endmodule

bind adc_start_seq adc_start_seq_chk #(.NUM_CH(NUM_CH), .CHW(CHW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_bit    (start_bit),
    .sample_strobe(sample_strobe),
    .busy         (busy),
    .conv_done    (conv_done),
    .scan_cfg     (scan_cfg),
    .chan_idx     (chan_idx)
);

// File: tb/tb_adc_start_seq.sv
module tb_adc_start_seq;
    localparam int NUM_CH = 4;
    localparam int CHW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_trig_n = 1'b1;
    logic reg_we = 1'b0, reg_start = 1'b0, reg_scan = 1'b0;
    logic [1:0] reg_trig_sel = 2'd0, reg_clk_sel = 2'd0;
    logic start_bit, sample_strobe, busy, conv_done;
    logic [CHW-1:0] chan_idx;

    adc_start_seq #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .ext_trig_n(ext_trig_n),
        .reg_we(reg_we), .reg_start(reg_start), .reg_scan(reg_scan),
        .reg_trig_sel(reg_trig_sel), .reg_clk_sel(reg_clk_sel),
        .start_bit(start_bit), .sample_strobe(sample_strobe), .busy(busy),
        .conv_done(conv_done), .chan_idx(chan_idx)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cyc);
            summary();
            $finish;
        end
    end

    function automatic int f_t(int c); return 512 >> c; endfunction
    function automatic int f_s(int c); return f_t(c) / 4 - 1; endfunction
    function automatic int f_d(int c); return f_t(c) / 32 + 2; endfunction

    task automatic chk_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic sw_wr(bit st, bit sc, logic [1:0] ts, logic [1:0] ck);
        reg_we = 1'b1; reg_start = st; reg_scan = sc;
        reg_trig_sel = ts; reg_clk_sel = ck;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // called at the negedge where start reads 1 and busy is still 0
    task automatic measure_single(int c, int inj);
        int nb = 0, ns = 0, first = 0, it = 0;
        int exp_b = f_d(c) + f_t(c);
        while (1) begin
            @(negedge clk);
            reg_we = 1'b0;
            it++;
            if (it == 1) chk_eq("R1 busy one clock after start", busy, 1);
            if (conv_done || it > 2000) break;
            if (busy) nb++;
            if (sample_strobe) begin
                ns++;
                if (first == 0) first = nb;
            end
            if (inj == 1 && nb == exp_b - 2) ext_trig_n = 1'b0;
            if (inj == 2 && nb == 1) begin
                reg_we = 1'b1; reg_start = 1'b1; reg_scan = 1'b1;
                reg_trig_sel = 2'd0; reg_clk_sel = 2'(c) ^ 2'd3;
            end
        end
        chk_eq(inj == 2 ? "R8 busy length kept" : "R3 busy length", nb, exp_b);
        chk_eq("R4 strobe length", ns, f_s(c));
        chk_eq("R4 strobe start state", first, f_d(c) + 1);
        chk_eq("R5 done pulse", conv_done, 1);
        chk_eq(inj == 2 ? "R8 stays single" : "R5 start cleared", start_bit, 0);
        chk_eq("R5 busy low at done", busy, 0);
        @(negedge clk);
        chk_eq("R5 done one clock", conv_done, 0);
        if (inj == 1) begin
            repeat (4) @(negedge clk);
            chk_eq("R9 no restart start", start_bit, 0);
            chk_eq("R9 no restart busy", busy, 0);
            ext_trig_n = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic start_sw(int c, int inj);
        sw_wr(1'b1, 1'b0, 2'd3, 2'(c));
        chk_eq("R1 start bit set", start_bit, 1);
        chk_eq("R1 busy not yet", busy, 0);
        measure_single(c, inj);
    endtask

    task automatic start_trig(int c);
        sw_wr(1'b0, 1'b0, 2'd3, 2'(c));
        ext_trig_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R2 start not early", start_bit, 0);
        @(negedge clk);
        chk_eq("R2 pin sets start", start_bit, 1);
        chk_eq("R2 busy not yet", busy, 0);
        measure_single(c, 0);
        ext_trig_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int cnt, ns;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_eq("R11 start reset", start_bit, 0);
        chk_eq("R11 busy reset", busy, 0);
        chk_eq("R11 strobe reset", sample_strobe, 0);
        chk_eq("R11 done reset", conv_done, 0);
        chk_eq("R11 chan reset", chan_idx, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed single mode over every clock select
        for (int c = 0; c < 4; c++) start_sw(c, 0);
        start_trig(1);

        // R2: other trigger selects ignore the pin
        sw_wr(1'b0, 1'b0, 2'd2, 2'd3);
        ext_trig_n = 1'b0;
        repeat (5) @(negedge clk);
        chk_eq("R2 pin ignored start", start_bit, 0);
        chk_eq("R2 pin ignored busy", busy, 0);
        ext_trig_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: edge detected in the final busy state
        start_sw(3, 1);
        // R8: configuration writes during a conversion
        start_sw(2, 2);

        // R10: clearing write in the same cycle as a detected edge
        sw_wr(1'b0, 1'b0, 2'd3, 2'd3);
        ext_trig_n = 1'b0;
        repeat (2) @(negedge clk);
        sw_wr(1'b0, 1'b0, 2'd3, 2'd3);
        chk_eq("R10 write wins", start_bit, 0);
        repeat (3) @(negedge clk);
        chk_eq("R10 still idle", busy, 0);
        ext_trig_n = 1'b1;
        repeat (4) @(negedge clk);

        // random single conversions
        for (int k = 0; k < 8; k++) begin
            int c = int'($urandom % 4);
            if ($urandom % 2 == 1) start_trig(c);
            else start_sw(c, 0);
        end

        // R6: scan mode with clock select 10
        ns = 0;
        sw_wr(1'b1, 1'b1, 2'd0, 2'd2);
        chk_eq("R6 start set", start_bit, 1);
        for (int k = 0; k < NUM_CH + 2; k++) begin
            cnt = 0;
            while (1) begin
                @(negedge clk);
                cnt++;
                if (k == 0 && cnt == 1) chk_eq("R6 no delay strobe", sample_strobe, 1);
                if (sample_strobe) ns++;
                if (conv_done || cnt > 2000) break;
            end
            chk_eq("R6 slot length", cnt, (k == 0) ? f_t(2) + 1 : f_t(2));
            chk_eq("R6 next channel", chan_idx, (k + 1) % NUM_CH);
            chk_eq("R6 start held", start_bit, 1);
            chk_eq("R6 busy held", busy, 1);
        end
        chk_eq("R6 strobe total", ns, (NUM_CH + 2) * f_s(2) + 1);

        // R7: abort in the middle of a sampling window
        repeat (10) @(negedge clk);
        sw_wr(1'b0, 1'b1, 2'd0, 2'd2);
        chk_eq("R7 busy cleared", busy, 0);
        chk_eq("R7 start cleared", start_bit, 0);
        chk_eq("R7 chan cleared", chan_idx, 0);
        chk_eq("R7 strobe cleared", sample_strobe, 0);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (conv_done || busy) cnt++;
        end
        chk_eq("R7 no done after abort", cnt, 0);

        summary();
        $finish;
    end
endmodule